// File: doc/BRIEF.md
# Ordered Multi-Channel Break Sequencer

This block turns single-cycle match strobes from a bank of event channels into a halt request. A halt is raised only when a chosen set of channels matches in a set order. A 4-bit mode input picks how the order is defined. It can be a two-channel chain, a longer fixed ladder of channels, or an extended mode. In extended mode each channel names its own prerequisite. That prerequisite is either another channel or a shared match flag, and a channel's match may also set or clear that flag.

When a sequence completes, the block emits a one-cycle halt pulse and raises a pending level. The pending level stays high until the debugger acknowledges it. The same break resets all sequence progress and the match flag. The flag is brought out so that software can see it. The comparators that produce the match strobes sit outside this block. Channels are numbered 1 to NCH, and channel n drives bit n-1 of `match_i`.

Top module: `seq_break_top`

## Requirements
- R1: After reset, `halt_o`, `halt_pend_o` and `flag_o` are low, and no sequence progress is held.
- R2: Pair modes are selected by mode code: 1 = ch2 then ch1, 2 = ch4 then ch3, 3 = ch6 then ch5, 4 = ch11 then ch10, 5 = ch9 then ch8, 6 = ch8 then ch9. A break occurs only when the second channel matches in a cycle after the first has matched.
- R3: Mode codes 7 to 12 select ladder chains of length 3 to 8. The ladder is ch1, ch2, ch3, ch4, ch5, ch6, ch10, ch11. A chain of length L uses the first L ladder entries. They must match from the highest entry down to ch1, and the match of ch1 raises the break.
- R4: In pair and ladder modes, a match on any channel other than the next one expected leaves the progress unchanged. It neither advances nor resets the progress.
- R5: In mode 13 (extended), each channel's 4-bit prerequisite field sits at bits [4(n-1)+3 : 4(n-1)] of `pre_sel_i`. Code 0 means no prerequisite. Code j (1..12) means the channel's match counts only if channel j already gave a counted match in an earlier cycle since the last clear.
- R6: In extended mode, prerequisite code 15 makes a channel's match count only while the match flag is set.
- R7: In extended mode, each channel's 2-bit action field sits at bits [2(n-1)+1 : 2(n-1)] of `flag_act_i`. Code 01 sets the flag on a counted match, and code 10 clears it. If a set and a clear occur in the same cycle, the clear wins. The flag is visible on `flag_o`, and matches in other modes never change it.
- R8: In extended mode, a counted match breaks unless one of two things holds. Either the channel is named as a prerequisite by some channel, or the channel's action code is 01 or 10. In either case the match does not break.
- R9: A break clears the match flag and all sequence progress on the same edge on which `halt_o` rises.
- R10: `halt_o` is high for exactly the one cycle after the edge that sampled the completing match. `halt_pend_o` rises with it and stays high until an edge samples `brk_ack_i` high. A break on the same edge as an acknowledge leaves `halt_pend_o` high.
- R11: A change of `mode_i` clears progress and the flag. Modes 0, 14 and 15 never break.
- R12: Prerequisite codes 13 and 14 make a channel's matches never count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | Chain mode code |
| match_i | input | NCH | Per-channel match strobes, bit n-1 for channel n |
| pre_sel_i | input | NCH*4 | Per-channel prerequisite codes (extended mode) |
| flag_act_i | input | NCH*2 | Per-channel flag action codes (extended mode) |
| brk_ack_i | input | 1 | Break acknowledge, clears the pending level |
| halt_o | output | 1 | One-cycle halt pulse |
| halt_pend_o | output | 1 | Halt pending until acknowledged |
| flag_o | output | 1 | Current match flag |

## Verification
A completing match and a break acknowledge can land on the same clock edge. The bench provokes this by repeatedly striking a channel in extended mode that breaks on every match, and it drives the acknowledge together with the second strike. It judges the result by requiring both `halt_o` and `halt_pend_o` to be high after that edge, and then requiring a later lone acknowledge to drop the pending level. A flag set and a flag clear in one cycle are also provoked together, and the flag must come out clear.

// File: rtl/seq_brk_pkg.sv
package seq_brk_pkg;

  localparam int MODEW      = 4;
  localparam int MAX_STAGES = 8;

  typedef enum logic [MODEW-1:0] {
    MODE_OFF    = 4'd0,
    MODE_P2_1   = 4'd1,
    MODE_P4_3   = 4'd2,
    MODE_P6_5   = 4'd3,
    MODE_P11_10 = 4'd4,
    MODE_P9_8   = 4'd5,
    MODE_P8_9   = 4'd6,
    MODE_C3     = 4'd7,
    MODE_C4     = 4'd8,
    MODE_C5     = 4'd9,
    MODE_C6     = 4'd10,
    MODE_C7     = 4'd11,
    MODE_C8     = 4'd12,
    MODE_EXT    = 4'd13
  } chain_mode_e;

  typedef enum logic [1:0] {
    FLG_KEEP = 2'b00,
    FLG_SET  = 2'b01,
    FLG_CLR  = 2'b10
  } flag_act_e;

  // Channel number held at ladder position i (0 = final stage)
  function automatic int unsigned ladder_chan(input int unsigned i);
    if (i < 6)       return i + 1;
    else if (i == 6) return 10;
    else             return 11;
  endfunction

  // Number of stages of a fixed chain mode, 0 when the mode is not fixed
  function automatic int unsigned chain_len(input logic [MODEW-1:0] m);
    if (m >= MODE_P2_1 && m <= MODE_P8_9) return 2;
    if (m >= MODE_C3 && m <= MODE_C8)     return 32'(m) - 4;
    return 0;
  endfunction

  // Channel number expected at step k (0 = first to match) of a fixed mode
  function automatic int unsigned chain_chan(input logic [MODEW-1:0] m,
                                             input int unsigned k);
    case (m)
      MODE_P2_1:   return (k == 0) ? 2  : 1;
      MODE_P4_3:   return (k == 0) ? 4  : 3;
      MODE_P6_5:   return (k == 0) ? 6  : 5;
      MODE_P11_10: return (k == 0) ? 11 : 10;
      MODE_P9_8:   return (k == 0) ? 9  : 8;
      MODE_P8_9:   return (k == 0) ? 8  : 9;
      default: begin
        if (m >= MODE_C3 && m <= MODE_C8)
          return ladder_chan(chain_len(m) - 1 - k);
        return 1;
      end
    endcase
  endfunction

endpackage

// File: rtl/seq_chain_fixed.sv
module seq_chain_fixed
  import seq_brk_pkg::*;
#(
  parameter int NCH = 12,
  localparam int CW  = $clog2(NCH),
  localparam int STW = $clog2(MAX_STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MODEW-1:0] mode_i,
  input  logic [NCH-1:0]   match_i,
  input  logic             clr_i,
  output logic             brk_o
);

  logic [STW-1:0] stage_q;
  int unsigned    len;
  int unsigned    want;
  logic [CW-1:0]  widx;
  logic           hit;
  logic           last;

  always_comb begin
    len  = chain_len(mode_i);
    want = chain_chan(mode_i, 32'(stage_q));
    widx = CW'(want - 1);
    hit  = (len != 0) && match_i[widx];
    last = (32'(stage_q) + 1) == len;
    brk_o = hit && last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           stage_q <= '0;
    else if (clr_i)       stage_q <= '0;
    else if (hit && !last) stage_q <= stage_q + 1'b1;
  end

endmodule

// File: rtl/seq_chain_ext.sv
module seq_chain_ext
  import seq_brk_pkg::*;
#(
  parameter int NCH = 12,
  localparam int SELW = $clog2(NCH + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [NCH-1:0]      match_i,
  input  logic [NCH*SELW-1:0] pre_sel_i,
  input  logic [NCH*2-1:0]    flag_act_i,
  input  logic                clr_i,
  output logic                brk_o,
  output logic                flag_o
);

  localparam logic [SELW-1:0] FLAG_CODE = '1;

  logic [NCH-1:0] hit_q;
  logic           flag_q;
  logic [NCH-1:0] pre_ok;
  logic [NCH-1:0] is_pre;
  logic [NCH-1:0] act_set;
  logic [NCH-1:0] act_clr;
  logic [NCH-1:0] eff;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SELW-1:0] sel;
    assign sel        = pre_sel_i[i*SELW +: SELW];
    assign act_set[i] = flag_act_i[2*i +: 2] == FLG_SET;
    assign act_clr[i] = flag_act_i[2*i +: 2] == FLG_CLR;

    always_comb begin
      pre_ok[i] = (sel == '0) || ((sel == FLAG_CODE) && flag_q);
      for (int j = 0; j < NCH; j++)
        if ((sel == SELW'(j + 1)) && hit_q[j]) pre_ok[i] = 1'b1;
    end
  end

  // A channel named by any other channel is a quiet stage
  always_comb begin
    is_pre = '0;
    for (int k = 0; k < NCH; k++)
      for (int j = 0; j < NCH; j++)
        if (pre_sel_i[k*SELW +: SELW] == SELW'(j + 1)) is_pre[j] = 1'b1;
  end

  assign eff    = {NCH{en_i}} & match_i & pre_ok;
  assign brk_o  = |(eff & ~is_pre & ~act_set & ~act_clr);
  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      hit_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      hit_q <= hit_q | eff;
      if (|(eff & act_clr))      flag_q <= 1'b0;
      else if (|(eff & act_set)) flag_q <= 1'b1;
    end
  end

endmodule

// File: rtl/seq_halt_ctl.sv
module seq_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_i,
  input  logic ack_i,
  output logic halt_o,
  output logic pend_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_o <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      halt_o <= brk_i;
      if (brk_i)      pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end

endmodule

// File: rtl/seq_break_top.sv
module seq_break_top
  import seq_brk_pkg::*;
#(
  parameter int NCH = 12,
  localparam int SELW = $clog2(NCH + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODEW-1:0]    mode_i,
  input  logic [NCH-1:0]      match_i,
  input  logic [NCH*SELW-1:0] pre_sel_i,
  input  logic [NCH*2-1:0]    flag_act_i,
  input  logic                brk_ack_i,
  output logic                halt_o,
  output logic                halt_pend_o,
  output logic                flag_o
);

  logic [MODEW-1:0] mode_q;
  logic             mode_chg;
  logic             fix_brk;
  logic             ext_brk;
  logic             brk;
  logic             clr;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_i;
  end

  assign mode_chg = mode_q != mode_i;
  assign brk      = fix_brk | ext_brk;
  assign clr      = brk | mode_chg;

  seq_chain_fixed #(.NCH(NCH)) u_fixed (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .match_i (match_i),
    .clr_i   (clr),
    .brk_o   (fix_brk)
  );

  seq_chain_ext #(.NCH(NCH)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (mode_i == MODE_EXT),
    .match_i    (match_i),
    .pre_sel_i  (pre_sel_i),
    .flag_act_i (flag_act_i),
    .clr_i      (clr),
    .brk_o      (ext_brk),
    .flag_o     (flag_o)
  );

  seq_halt_ctl u_halt (
    .clk    (clk),
    .rst_n  (rst_n),
    .brk_i  (brk),
    .ack_i  (brk_ack_i),
    .halt_o (halt_o),
    .pend_o (halt_pend_o)
  );

endmodule

// File: rtl/seq_break_chk.sv
module seq_break_chk
  import seq_brk_pkg::*;
#(
  parameter int NCH = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MODEW-1:0] mode_i,
  input logic [NCH-1:0]   match_i,
  input logic             brk_ack_i,
  input logic             halt_o,
  input logic             halt_pend_o,
  input logic             flag_o
);

  a_r10_pulse_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> halt_pend_o);

  a_r10_pending_rises_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_pend_o) |-> halt_o);

  a_r10_pending_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_pend_o) |-> $past(brk_ack_i));

  a_r9_flag_clear_on_break: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !flag_o);

  a_r11_break_needs_mode_and_match: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> ($past(mode_i) != MODE_OFF) && ($past(mode_i) <= MODE_EXT)
               && $past(|match_i));

  a_r7_flag_rises_only_extended: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> ($past(mode_i) == MODE_EXT));

endmodule

bind seq_break_top seq_break_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .match_i     (match_i),
  .brk_ack_i   (brk_ack_i),
  .halt_o      (halt_o),
  .halt_pend_o (halt_pend_o),
  .flag_o      (flag_o)
);

// File: tb/sim_seq_break_top.sv
module sim_seq_break_top;

  localparam int NCH  = 12;
  localparam int SELW = 4;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [3:0]          mode;
  logic [NCH-1:0]      match;
  logic [NCH*SELW-1:0] pre_sel;
  logic [NCH*2-1:0]    fact;
  logic                ack;
  logic                halt, pend, flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  seq_break_top #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .match_i(match),
    .pre_sel_i(pre_sel), .flag_act_i(fact), .brk_ack_i(ack),
    .halt_o(halt), .halt_pend_o(pend), .flag_o(flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] ch(input int n);
    return NCH'(1) << (n - 1);
  endfunction

  // Drive one cycle of matches; return at the negedge after the sampling edge
  task automatic strike(input logic [NCH-1:0] m);
    @(negedge clk) match = m;
    @(negedge clk) match = '0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk) mode = m;
    @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic clear_cfg();
    pre_sel = '0;
    fact    = '0;
  endtask

  task automatic set_pre(input int n, input logic [3:0] code);
    pre_sel[(n-1)*SELW +: SELW] = code;
  endtask

  task automatic set_act(input int n, input logic [1:0] code);
    fact[(n-1)*2 +: 2] = code;
  endtask

  task automatic t_reset();
    check("R1 halt", halt, 1'b0);
    check("R1 pend", pend, 1'b0);
    check("R1 flag", flag, 1'b0);
  endtask

  task automatic t_pair21();
    set_mode(4'd1);
    strike(ch(1));
    check("R4 ch1 before ch2", halt, 1'b0);
    strike(ch(2));
    check("R2 first stage only", halt, 1'b0);
    strike(ch(1));
    check("R2 pair 2->1 break", halt, 1'b1);
    check("R10 pending rises", pend, 1'b1);
    @(negedge clk);
    check("R10 pulse one cycle", halt, 1'b0);
    check("R10 pending held", pend, 1'b1);
    do_ack();
    check("R10 pending cleared by ack", pend, 1'b0);
  endtask

  task automatic t_pair98();
    set_mode(4'd5);
    strike(ch(8));
    check("R4 ch8 first in 9->8", halt, 1'b0);
    strike(ch(9));
    strike(ch(8));
    check("R2 pair 9->8 break", halt, 1'b1);
    do_ack();
    strike(ch(8));
    check("R9 progress reset after break", halt, 1'b0);
    set_mode(4'd6);
    strike(ch(8));
    strike(ch(9));
    check("R2 pair 8->9 break", halt, 1'b1);
    do_ack();
  endtask

  task automatic t_ladder5();
    set_mode(4'd9);
    strike(ch(5));
    strike(ch(4));
    strike(ch(1));
    check("R4 out of order in ladder", halt, 1'b0);
    strike(ch(3));
    strike(ch(2));
    check("R3 no break before ch1", halt, 1'b0);
    strike(ch(1));
    check("R3 ladder length 5 break", halt, 1'b1);
    do_ack();
  endtask

  task automatic t_ladder8();
    int seq [8] = '{11, 10, 6, 5, 4, 3, 2, 1};
    logic seen;
    set_mode(4'd12);
    seen = 1'b0;
    for (int k = 0; k < 7; k++) begin
      strike(ch(seq[k]));
      seen = seen | halt;
    end
    check("R3 ladder length 8 early", seen, 1'b0);
    strike(ch(seq[7]));
    check("R3 ladder length 8 break", halt, 1'b1);
    do_ack();
  endtask

  task automatic t_ext_prereq();
    clear_cfg();
    set_pre(3, 4'd2);
    set_mode(4'd13);
    strike(ch(3));
    check("R5 ch3 without prerequisite", halt, 1'b0);
    strike(ch(2) | ch(3));
    check("R5 same-cycle prerequisite not counted", halt, 1'b0);
    strike(ch(2));
    check("R8 prerequisite channel quiet", halt, 1'b0);
    strike(ch(3));
    check("R5 ch3 after ch2 breaks", halt, 1'b1);
    do_ack();
    strike(ch(3));
    check("R9 hits cleared by break", halt, 1'b0);
  endtask

  task automatic t_ext_flag();
    clear_cfg();
    set_act(4, 2'b01);
    set_act(5, 2'b10);
    set_pre(6, 4'd15);
    set_mode(4'd0);
    set_mode(4'd13);
    strike(ch(6));
    check("R6 flag prerequisite unmet", halt, 1'b0);
    strike(ch(4));
    check("R7 set action", flag, 1'b1);
    check("R8 flag-action channel quiet", halt, 1'b0);
    strike(ch(5));
    check("R7 clear action", flag, 1'b0);
    strike(ch(4));
    strike(ch(4) | ch(5));
    check("R7 clear wins over set", flag, 1'b0);
    strike(ch(4));
    strike(ch(6));
    check("R6 flag prerequisite met", halt, 1'b1);
    check("R9 flag cleared by break", flag, 1'b0);
    do_ack();
  endtask

  task automatic t_ack_collide();
    clear_cfg();
    set_mode(4'd13);
    strike(ch(7));
    check("R8 plain channel breaks", halt, 1'b1);
    @(negedge clk) begin match = ch(7); ack = 1'b1; end
    @(negedge clk) begin match = '0; ack = 1'b0; end
    check("R10 break with ack: pulse", halt, 1'b1);
    check("R10 break with ack: pending kept", pend, 1'b1);
    do_ack();
    check("R10 lone ack clears", pend, 1'b0);
  endtask

  task automatic t_mode_change();
    logic seen;
    clear_cfg();
    set_act(4, 2'b01);
    set_mode(4'd13);
    strike(ch(4));
    check("R7 flag set before change", flag, 1'b1);
    set_mode(4'd1);
    check("R11 mode change clears flag", flag, 1'b0);
    strike(ch(2));
    set_mode(4'd2);
    set_mode(4'd1);
    strike(ch(1));
    check("R11 mode change clears progress", halt, 1'b0);
    strike(ch(2));
    strike(ch(1));
    check("R7 fixed mode keeps flag", flag, 1'b0);
    check("R2 pair after mode change", halt, 1'b1);
    do_ack();
    set_mode(4'd0);
    seen = 1'b0;
    for (int k = 0; k < 3; k++) begin
      strike('1);
      seen = seen | halt;
    end
    check("R11 off mode never breaks", seen, 1'b0);
  endtask

  task automatic t_bad_code();
    clear_cfg();
    set_pre(8, 4'd13);
    set_pre(9, 4'd14);
    set_mode(4'd13);
    strike(ch(8) | ch(9));
    check("R12 invalid codes never count", halt, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    mode  = 4'd0;
    match = '0;
    ack   = 1'b0;
    clear_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair21();
    t_pair98();
    t_ladder5();
    t_ladder8();
    t_ext_prereq();
    t_ext_flag();
    t_ack_collide();
    t_mode_change();
    t_bad_code();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule